// File: doc/BRIEF.md
# Link Power-State Entry Timer

This block decides when an endpoint link controller should ask to move the link into one of two low-power states: the short-exit standby state L0s and the deeper L1 state. It watches a link-idle indication and one power-state bit per function. Two programmable cycle counts set how long each condition must last before the matching request is raised. Both counts sit in a single read/write configuration word.

The L0s request rises once the link has been idle for the programmed L0s entry time. The L1 request rises once every function has been out of D0 for the programmed L1 wait period. Each request is a level. It stays high until the link state machine acknowledges it or the condition behind it goes away. The software-visible value is the time in microseconds multiplied by the core clock frequency in MHz. The reset values correspond to 6 µs for L0s entry and 1 µs for the L1 wait at 333 MHz.

Top module: `link_pm_entry_timer`

## Requirements
- R1: After reset both requests are low and the configuration word reads 0x0014D7CE (L1 wait 0x14D, L0s entry time 0x7CE).
- R2: In the configuration word, bits 11:0 hold the L0s entry time and bits 23:12 hold the L1 wait period. Bits 31:24 always read zero, whatever is written to them.
- R3: With a nonzero L0s entry time N, the L0s request is high in the cycle after the N-th consecutive clock edge at which the link was sampled idle, and not before.
- R4: With a nonzero L1 wait N, the L1 request is high after N consecutive edges at which every function bit reads 1 (1 means non-D0). If any single function bit is 0, the L1 count does not advance.
- R5: A non-idle link cycle drops the L0s request and clears its count. A function returning to D0 does the same for L1. The next qualifying interval counts again from zero.
- R6: An acknowledge while a request is high drops that request on the next edge. The request does not rise again until its condition has been broken and a new interval has completed.
- R7: A programmed value of zero prevents the corresponding request from ever rising.
- R8: A configuration write during a count does not change that count's threshold. The new value applies from the next interval start.
- R9: The link-idle input has no effect on the L1 request, and the function bits have no effect on the L0s request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller core clock |
| rst | input | 1 | Synchronous active-high reset |
| fn_nond0 | input | NUM_FN | Per-function flag, 1 when that function is in a non-D0 state |
| link_idle | input | 1 | 1 when no traffic is on the link this cycle |
| l0s_ack | input | 1 | Link state machine accepts the L0s request |
| l1_ack | input | 1 | Link state machine accepts the L1 request |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data |
| l0s_req | output | 1 | Request to enter L0s |
| l1_req | output | 1 | Request to enter L1 |

## Verification
The bench builds the block with three functions and the default 12-bit fields and reset values. The full reset thresholds of 1998 and 333 cycles therefore run to completion once, with both timers active over the same stretch. Reprogramming to thresholds of 3 to 5 cycles then brings within reach interrupted intervals, acknowledges, a partly powered-down function set, zero values and a rewrite in the middle of a count, each in a few dozen cycles.

// File: rtl/lpe_pkg.sv
package lpe_pkg;

    localparam int CFG_W   = 32;
    localparam int FIELD_W = 12;

    // Field placement inside the configuration word
    localparam int L0S_LSB = 0;
    localparam int L1_LSB  = 12;
    localparam int RSV_LSB = 24;

    localparam logic [FIELD_W-1:0] L0S_RESET = 12'h7CE;
    localparam logic [FIELD_W-1:0] L1_RESET  = 12'h14D;

    // Index of each entry timer in the timer array
    localparam int IDX_L0S = 0;
    localparam int IDX_L1  = 1;
    localparam int N_TIMER = 2;

    typedef struct packed {
        logic [FIELD_W-1:0] l1_wait;
        logic [FIELD_W-1:0] l0s_time;
    } pm_cfg_t;

    function automatic pm_cfg_t cfg_unpack(input logic [CFG_W-1:0] w);
        pm_cfg_t c;
        c.l0s_time = w[L0S_LSB +: FIELD_W];
        c.l1_wait  = w[L1_LSB  +: FIELD_W];
        return c;
    endfunction

    function automatic logic [CFG_W-1:0] cfg_pack(input pm_cfg_t c);
        logic [CFG_W-1:0] w;
        w = '0;
        w[L0S_LSB +: FIELD_W] = c.l0s_time;
        w[L1_LSB  +: FIELD_W] = c.l1_wait;
        return w;
    endfunction

endpackage

// File: rtl/lpe_cfg_reg.sv
module lpe_cfg_reg
    import lpe_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] rdata,
    output pm_cfg_t          cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.l0s_time <= L0S_RESET;
            cfg.l1_wait  <= L1_RESET;
        end else if (we) begin
            cfg <= cfg_unpack(wdata);
        end
    end

    // Reserved upper byte is not stored and reads as zero
    always_comb rdata = cfg_pack(cfg);

endmodule

// File: rtl/lpe_fn_gate.sv
module lpe_fn_gate #(
    parameter int NUM_FN = 4
) (
    input  logic [NUM_FN-1:0] fn_nond0,
    output logic              all_low_power
);

    generate
        if (NUM_FN == 1) begin : g_single
            assign all_low_power = fn_nond0[0];
        end else begin : g_multi
            assign all_low_power = &fn_nond0;
        end
    endgenerate

endmodule

// File: rtl/lpe_entry_timer.sv
module lpe_entry_timer #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cond,
    input  logic         ack,
    input  logic [W-1:0] thr_in,
    output logic         req
);

    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] ZERO = '0;

    logic         running;
    logic         done;
    logic [W-1:0] cnt;
    logic [W-1:0] thr;
    logic [W-1:0] thr_eff;
    logic [W-1:0] cnt_nxt;

    // Threshold is captured at the start of an interval
    always_comb begin
        thr_eff = running ? thr : thr_in;
        cnt_nxt = running ? (cnt + ONE) : ONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            done    <= 1'b0;
            cnt     <= '0;
            thr     <= '0;
            req     <= 1'b0;
        end else if (!cond) begin
            running <= 1'b0;
            done    <= 1'b0;
            cnt     <= '0;
            req     <= 1'b0;
        end else begin
            running <= 1'b1;
            if (!running) begin
                thr <= thr_in;
            end
            if (!done) begin
                cnt <= cnt_nxt;
                if (thr_eff != ZERO && cnt_nxt == thr_eff) begin
                    req  <= 1'b1;
                    done <= 1'b1;
                end
            end else if (ack) begin
                req <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/link_pm_entry_timer.sv
module link_pm_entry_timer
    import lpe_pkg::*;
#(
    parameter int NUM_FN = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_FN-1:0] fn_nond0,
    input  logic              link_idle,
    input  logic              l0s_ack,
    input  logic              l1_ack,
    input  logic              cfg_we,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              l0s_req,
    output logic              l1_req
);

    pm_cfg_t cfg;
    logic    all_low_power;

    logic [N_TIMER-1:0]              t_cond;
    logic [N_TIMER-1:0]              t_ack;
    logic [N_TIMER-1:0]              t_req;
    logic [N_TIMER-1:0][FIELD_W-1:0] t_thr;

    lpe_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .cfg   (cfg)
    );

    lpe_fn_gate #(.NUM_FN(NUM_FN)) u_gate (
        .fn_nond0      (fn_nond0),
        .all_low_power (all_low_power)
    );

    always_comb begin
        t_cond[IDX_L0S] = link_idle;
        t_ack [IDX_L0S] = l0s_ack;
        t_thr [IDX_L0S] = cfg.l0s_time;
        t_cond[IDX_L1]  = all_low_power;
        t_ack [IDX_L1]  = l1_ack;
        t_thr [IDX_L1]  = cfg.l1_wait;
    end

    generate
        for (genvar i = 0; i < N_TIMER; i++) begin : g_timer
            lpe_entry_timer #(.W(FIELD_W)) u_tmr (
                .clk    (clk),
                .rst    (rst),
                .cond   (t_cond[i]),
                .ack    (t_ack[i]),
                .thr_in (t_thr[i]),
                .req    (t_req[i])
            );
        end
    endgenerate

    assign l0s_req = t_req[IDX_L0S];
    assign l1_req  = t_req[IDX_L1];

endmodule

// File: rtl/link_pm_entry_timer_chk.sv
module link_pm_entry_timer_chk #(
    parameter int NUM_FN = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_FN-1:0] fn_nond0,
    input logic              link_idle,
    input logic              l0s_ack,
    input logic              l1_ack,
    input logic [31:0]       cfg_rdata,
    input logic              l0s_req,
    input logic              l1_req
);

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!l0s_req && !l1_req));

    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[31:24] == 8'h00);

    p_l0s_rise_idle_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(l0s_req) |-> $past(link_idle));

    p_l1_rise_all_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(l1_req) |-> $past(&fn_nond0));

    p_l0s_busy_drop_r5: assert property (@(posedge clk) disable iff (rst)
        !link_idle |=> !l0s_req);

    p_l1_wake_drop_r5: assert property (@(posedge clk) disable iff (rst)
        !(&fn_nond0) |=> !l1_req);

    p_l0s_ack_drop_r6: assert property (@(posedge clk) disable iff (rst)
        (l0s_req && l0s_ack) |=> !l0s_req);

    p_l1_ack_drop_r6: assert property (@(posedge clk) disable iff (rst)
        (l1_req && l1_ack) |=> !l1_req);

endmodule

bind link_pm_entry_timer link_pm_entry_timer_chk #(.NUM_FN(NUM_FN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .fn_nond0  (fn_nond0),
    .link_idle (link_idle),
    .l0s_ack   (l0s_ack),
    .l1_ack    (l1_ack),
    .cfg_rdata (cfg_rdata),
    .l0s_req   (l0s_req),
    .l1_req    (l1_req)
);

// File: tb/link_pm_entry_timer_bench.sv
module link_pm_entry_timer_bench;

    localparam int NF = 3;
    localparam logic [NF-1:0] ALL = '1;
    localparam logic [NF-1:0] NONE = '0;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NF-1:0] fn_nond0 = '0;
    logic          link_idle = 1'b0;
    logic          l0s_ack = 1'b0;
    logic          l1_ack = 1'b0;
    logic          cfg_we = 1'b0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic          l0s_req;
    logic          l1_req;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    typedef struct {
        logic  e0;
        logic  e1;
        string tag;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;

    link_pm_entry_timer #(.NUM_FN(NF)) u_link_pm_entry_timer (
        .clk       (clk),
        .rst       (rst),
        .fn_nond0  (fn_nond0),
        .link_idle (link_idle),
        .l0s_ack   (l0s_ack),
        .l1_ack    (l1_ack),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .l0s_req   (l0s_req),
        .l1_req    (l1_req)
    );

    task automatic check1(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: after each edge, pop one expectation and compare
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check1({e.tag, " l0s_req"}, {31'b0, l0s_req}, {31'b0, e.e0});
                check1({e.tag, " l1_req"},  {31'b0, l1_req},  {31'b0, e.e1});
            end
        end
    end

    // Driver: apply inputs for one cycle and push the outcome after its edge
    task automatic cyc(input logic idle, input logic [NF-1:0] fn,
                       input logic a0, input logic a1,
                       input logic we, input logic [31:0] wd,
                       input logic e0, input logic e1, input string tag);
        exp_t e;
        link_idle = idle;
        fn_nond0  = fn;
        l0s_ack   = a0;
        l1_ack    = a1;
        cfg_we    = we;
        cfg_wdata = wd;
        e.e0 = e0;
        e.e1 = e1;
        e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        l0s_ack = 1'b0;
        l1_ack  = 1'b0;
        cfg_we  = 1'b0;
    endtask

    task automatic quiet(input string tag);
        cyc(1'b0, NONE, 1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b0, tag);
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check1("R1 cfg reset", cfg_rdata, 32'h0014D7CE);
        check1("R1 reqs low", {30'b0, l0s_req, l1_req}, 32'h0);

        // R3 R4 R9: reset thresholds 1998 (L0s) and 333 (L1) in parallel
        for (int i = 1; i <= 2000; i++)
            cyc(1'b1, ALL, 1'b0, 1'b0, 1'b0, '0, i >= 1998, i >= 333, "R3/R4 default");
        quiet("R5 both cleared");

        // R2: write with junk in reserved byte
        cyc(1'b0, NONE, 1'b0, 1'b0, 1'b1, 32'hAB004005, 1'b0, 1'b0, "R2 write");
        check1("R2 readback", cfg_rdata, 32'h00004005);

        // R3 R9: L0s=5, functions in D0 do not matter
        for (int i = 1; i <= 7; i++)
            cyc(1'b1, NONE, 1'b0, 1'b0, 1'b0, '0, i >= 5, 1'b0, "R3 l0s=5");
        quiet("R5 busy drops l0s");

        // R5: interrupted run restarts from zero
        for (int i = 1; i <= 3; i++)
            cyc(1'b1, NONE, 1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R5 short run");
        quiet("R5 break");
        for (int i = 1; i <= 6; i++)
            cyc(1'b1, NONE, 1'b0, 1'b0, 1'b0, '0, i >= 5, 1'b0, "R5 restart");
        quiet("R5 break2");

        // R6: ack drops l0s, no re-raise in same interval
        for (int i = 1; i <= 5; i++)
            cyc(1'b1, NONE, 1'b0, 1'b0, 1'b0, '0, i >= 5, 1'b0, "R6 pre-ack");
        cyc(1'b1, NONE, 1'b1, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R6 l0s ack");
        for (int i = 1; i <= 8; i++)
            cyc(1'b1, NONE, 1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R6 stays low");
        quiet("R6 break");
        for (int i = 1; i <= 5; i++)
            cyc(1'b1, NONE, 1'b0, 1'b0, 1'b0, '0, i >= 5, 1'b0, "R6 new interval");
        quiet("R6 break3");

        // R4 R9: L1=4, link busy throughout
        for (int i = 1; i <= 5; i++)
            cyc(1'b0, ALL, 1'b0, 1'b0, 1'b0, '0, 1'b0, i >= 4, "R4 l1=4");
        cyc(1'b0, 3'b101, 1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R5 fn wakes");
        for (int i = 1; i <= 6; i++)
            cyc(1'b0, 3'b011, 1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R4 partial set");
        for (int i = 1; i <= 4; i++)
            cyc(1'b0, ALL, 1'b0, 1'b0, 1'b0, '0, 1'b0, i >= 4, "R4 all again");
        cyc(1'b0, ALL, 1'b0, 1'b1, 1'b0, '0, 1'b0, 1'b0, "R6 l1 ack");
        for (int i = 1; i <= 5; i++)
            cyc(1'b0, ALL, 1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R6 l1 stays low");
        quiet("R6 l1 break");

        // R8: rewrite L0s to 3 mid-count; current run still uses 5
        for (int i = 1; i <= 2; i++)
            cyc(1'b1, NONE, 1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R8 early");
        cyc(1'b1, NONE, 1'b0, 1'b0, 1'b1, 32'h00004003, 1'b0, 1'b0, "R8 write");
        for (int i = 4; i <= 6; i++)
            cyc(1'b1, NONE, 1'b0, 1'b0, 1'b0, '0, i >= 5, 1'b0, "R8 old thr");
        quiet("R8 break");
        for (int i = 1; i <= 4; i++)
            cyc(1'b1, NONE, 1'b0, 1'b0, 1'b0, '0, i >= 3, 1'b0, "R8 new thr");
        quiet("R8 break2");

        // R7: zero disables both
        cyc(1'b0, NONE, 1'b0, 1'b0, 1'b1, 32'hFF000000, 1'b0, 1'b0, "R7 write zero");
        check1("R7 readback", cfg_rdata, 32'h0);
        for (int i = 1; i <= 20; i++)
            cyc(1'b1, ALL, 1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R7 disabled");
        quiet("R7 end");

        @(posedge clk);
        #2;
        check1("scoreboard drained", sb.size(), 0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule